// File: doc/BRIEF.md
# Brown-out Reset Controller

This block turns a synchronous "supply is low" flag from an external comparator into a chip reset. A 2-bit mode input picks how detection is enabled. Detection can be off, gated by a software enable bit, on in hardware but dropped while the chip sleeps, or always on. A low flag that lasts only a few cycles is filtered out. A sustained low flag puts the block into brown-out. Reset is held while the supply stays low. Once the supply recovers, an optional settling delay runs before reset is released.

A power-on pulse from an external detector restarts the sequence. It forces reset, clears the filter and the status bits, and always runs the settling delay. Two software-visible status flags, one for power-on and one for brown-out, let firmware tell the cause of a reset. After each power-on, firmware writes the power-on flag back to 1. A later reset with the brown-out flag at 0 and the power-on flag at 1 was then a brown-out.

Top module: `bor_supervisor`

## Requirements
- R1: With `cfg_mode` = 2'b00, `vlow_i` never causes a reset, whatever the software enable bit has been written to.
- R2: With `cfg_mode` = 2'b01, writing 1 through `sw_en_wr`/`sw_en_wdata` turns detection on and writing 0 turns it off. `sw_en_rd` returns the stored value.
- R3: With `cfg_mode` = 2'b10, detection is on while `sleep_i` = 0 and off while `sleep_i` = 1. It resumes as soon as `sleep_i` returns to 0.
- R4: With `cfg_mode` = 2'b11, detection is on at all times, independent of the software bit and of `sleep_i`.
- R5: Outside `cfg_mode` = 2'b01, `sw_en_rd` reads 0, and writes to the software enable bit are ignored: the stored value is unchanged.
- R6: With detection on, `vlow_i` high for fewer than `GLITCH_CYC` consecutive rising edges causes no reset. High for `GLITCH_CYC` consecutive edges, it raises `chip_rst` right after the last of those edges.
- R7: Once in brown-out, `chip_rst` stays high for as long as `vlow_i` stays high.
- R8: After `vlow_i` falls in brown-out with `pwrt_en` = 1, `chip_rst` stays high for `PWRT_CYC` more cycles. With `pwrt_en` = 0 it falls one cycle after the recovery edge.
- R9: If `vlow_i` is high at any edge during the settling delay while detection is on, the block goes back to brown-out at once and the delay later restarts from zero.
- R10: `bor_flag` is cleared on every entry into brown-out. `stat_wr` loads both flags from `stat_por_wdata`/`stat_bor_wdata`. A hardware clear in the same cycle wins over the write.
- R11: `por_pulse` forces `chip_rst` high, clears both flags and the glitch filter, and runs the `PWRT_CYC` delay even when `pwrt_en` = 0.
- R12: While `rst_n` is low at an edge, the block returns to the running state: `chip_rst`, both flags and the software bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_pulse | input | 1 | Power-on event from external detector |
| vlow_i | input | 1 | Supply-below-threshold flag, synchronous |
| sleep_i | input | 1 | Chip is in sleep |
| cfg_mode | input | 2 | Enable policy: 00 off, 01 software, 10 hardware except sleep, 11 always |
| pwrt_en | input | 1 | Enable settling delay after brown-out recovery |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_wdata | input | 1 | Value written to the software enable bit |
| stat_wr | input | 1 | Write strobe for both status flags |
| stat_por_wdata | input | 1 | Value written to the power-on flag |
| stat_bor_wdata | input | 1 | Value written to the brown-out flag |
| sw_en_rd | output | 1 | Software enable readback (0 outside mode 01) |
| por_flag | output | 1 | Power-on status flag |
| bor_flag | output | 1 | Brown-out status flag |
| chip_rst | output | 1 | Reset request to the chip, active high |

## Verification
The bench probes the glitch filter on both sides of its limit. A dip one edge shorter than `GLITCH_CYC` must pass, and one of exactly that length must trip. An off-by-one counter would either reset on a tolerated dip or miss a real brown-out. It drops the low flag back in during the settling delay. A design that resumed the timer instead of restarting it would release reset early. It also writes the software enable bit in every mode and toggles sleep in mode 10. A wrongly decoded mode would trip with detection off or ignore a real low supply. Finally, it writes the status flags in the same cycle as a power-on or brown-out. A design that let the write win would hide the reset cause.

// File: rtl/bor_pkg.sv
// Shared types of the brown-out reset controller.
// Assumes: nothing beyond IEEE 1800-2017.
package bor_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BROWN = 2'd1,
        ST_DELAY = 2'd2
    } bor_state_e;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_SOFT      = 2'b01,
        MODE_HW_NOSLP  = 2'b10,
        MODE_ALWAYS    = 2'b11
    } bor_mode_e;

endpackage

// File: rtl/bor_enable_ctrl.sv
// Decodes the enable policy and holds the software enable bit.
// Assumes: cfg_mode is static or changes synchronously; the software
// bit is stored only while the software-gated mode is selected.
module bor_enable_ctrl
    import bor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       sleep_i,
    input  logic       sw_wr,
    input  logic       sw_wdata,
    output logic       det_en,
    output logic       sw_en_rd
);

    logic sw_en_q;
    logic soft_mode;

    assign soft_mode = (cfg_mode == MODE_SOFT);

    // Software enable register, writable only in the software-gated mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en_q <= 1'b0;
        end else if (sw_wr && soft_mode) begin
            sw_en_q <= sw_wdata;
        end
    end

    // Policy decode: which mode lets detection run this cycle.
    always_comb begin
        unique case (cfg_mode)
            MODE_OFF:      det_en = 1'b0;
            MODE_SOFT:     det_en = sw_en_q;
            MODE_HW_NOSLP: det_en = !sleep_i;
            default:       det_en = 1'b1;
        endcase
    end

    assign sw_en_rd = soft_mode && sw_en_q;

endmodule

// File: rtl/bor_glitch_filter.sv
// Counts consecutive cycles of a qualified low-supply flag and signals a
// trip on the GLITCH_CYC-th consecutive edge.
// Assumes: GLITCH_CYC >= 1; clr has priority over counting.
module bor_glitch_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic vlow,
    input  logic det_en,
    output logic trip
);

    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;

    logic qual;
    assign qual = vlow && det_en;

    generate
        if (GLITCH_CYC == 1) begin : g_nofilt
            // No filtering: any qualified low flag trips at once.
            assign trip = qual;
        end else begin : g_cnt
            logic [CW-1:0] cnt_q;
            logic          at_lim;

            assign at_lim = (cnt_q == CW'(GLITCH_CYC - 1));
            assign trip   = qual && at_lim;

            // Run-length counter of the qualified flag, saturating at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || clr || !qual) begin
                    cnt_q <= '0;
                end else if (!at_lim) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bor_seq_fsm.sv
// Reset sequencer: run, brown-out hold and settling delay.
// Assumes: trip comes from the glitch filter; por has top priority and
// always enters the delay; PWRT_CYC >= 1.
module bor_seq_fsm
    import bor_pkg::*;
#(
    parameter int PWRT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por,
    input  logic       trip,
    input  logic       vlow,
    input  logic       det_en,
    input  logic       pwrt_en,
    output bor_state_e state_o,
    output logic       bor_event,
    output logic       chip_rst
);

    localparam int TW = (PWRT_CYC > 1) ? $clog2(PWRT_CYC) : 1;

    bor_state_e    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          tmr_done;

    assign tmr_done = (tmr_q == TW'(PWRT_CYC - 1));

    // Next-state and timer logic of the sequencer.
    always_comb begin
        state_d   = state_q;
        tmr_d     = tmr_q;
        bor_event = 1'b0;
        if (por) begin
            state_d = ST_DELAY;
            tmr_d   = '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (trip) begin
                        state_d   = ST_BROWN;
                        bor_event = 1'b1;
                    end
                end
                ST_BROWN: begin
                    if (!vlow) begin
                        state_d = pwrt_en ? ST_DELAY : ST_RUN;
                        tmr_d   = '0;
                    end
                end
                ST_DELAY: begin
                    if (vlow && det_en) begin
                        state_d   = ST_BROWN;
                        bor_event = 1'b1;
                        tmr_d     = '0;
                    end else if (tmr_done) begin
                        state_d = ST_RUN;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                default: state_d = ST_RUN;
            endcase
        end
    end

    // State and timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    assign state_o  = state_q;
    assign chip_rst = (state_q != ST_RUN);

endmodule

// File: rtl/bor_status_regs.sv
// Power-on and brown-out status flags with software write access.
// Assumes: hardware clear events win over a software write in the same cycle.
module bor_status_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic bor_event,
    input  logic wr,
    input  logic wd_por,
    input  logic wd_bor,
    output logic por_flag,
    output logic bor_flag
);

    // Power-on flag: cleared by a power-on event, else loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n || por) begin
            por_flag <= 1'b0;
        end else if (wr) begin
            por_flag <= wd_por;
        end
    end

    // Brown-out flag: cleared by any reset event, else loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n || por || bor_event) begin
            bor_flag <= 1'b0;
        end else if (wr) begin
            bor_flag <= wd_bor;
        end
    end

endmodule

// File: rtl/bor_supervisor.sv
// Top of the brown-out reset controller: wires the enable decode, the
// glitch filter, the reset sequencer and the status flags.
// Assumes: all inputs are synchronous to clk; the analog comparator and
// power-on detector live outside.
module bor_supervisor
    import bor_pkg::*;
#(
    parameter int GLITCH_CYC = 4,
    parameter int PWRT_CYC   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_pulse,
    input  logic       vlow_i,
    input  logic       sleep_i,
    input  logic [1:0] cfg_mode,
    input  logic       pwrt_en,
    input  logic       sw_en_wr,
    input  logic       sw_en_wdata,
    input  logic       stat_wr,
    input  logic       stat_por_wdata,
    input  logic       stat_bor_wdata,
    output logic       sw_en_rd,
    output logic       por_flag,
    output logic       bor_flag,
    output logic       chip_rst
);

    logic       det_en;
    logic       trip;
    logic       bor_event;
    bor_state_e fsm_state;

    bor_enable_ctrl u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .sleep_i  (sleep_i),
        .sw_wr    (sw_en_wr),
        .sw_wdata (sw_en_wdata),
        .det_en   (det_en),
        .sw_en_rd (sw_en_rd)
    );

    bor_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (por_pulse),
        .vlow   (vlow_i),
        .det_en (det_en),
        .trip   (trip)
    );

    bor_seq_fsm #(.PWRT_CYC(PWRT_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .por       (por_pulse),
        .trip      (trip),
        .vlow      (vlow_i),
        .det_en    (det_en),
        .pwrt_en   (pwrt_en),
        .state_o   (fsm_state),
        .bor_event (bor_event),
        .chip_rst  (chip_rst)
    );

    bor_status_regs u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .por       (por_pulse),
        .bor_event (bor_event),
        .wr        (stat_wr),
        .wd_por    (stat_por_wdata),
        .wd_bor    (stat_bor_wdata),
        .por_flag  (por_flag),
        .bor_flag  (bor_flag)
    );

endmodule

// File: rtl/bor_supervisor_chk.sv
// Property checker for bor_supervisor, attached by bind.
// Assumes: connected to the top's ports and its internal det_en/trip/state.
module bor_supervisor_chk
    import bor_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       por_pulse,
    input logic       vlow_i,
    input logic [1:0] cfg_mode,
    input logic       stat_wr,
    input logic       stat_bor_wdata,
    input logic       det_en,
    input logic       trip,
    input bor_state_e fsm_state,
    input logic       chip_rst,
    input logic       por_flag,
    input logic       bor_flag
);

    // R1: detection off never starts a reset from the running state.
    a_r1_mode_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_rst && cfg_mode == 2'b00 && !por_pulse) |=> !chip_rst);

    // R6: without a filter trip the running state is kept.
    a_r6_no_early_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_rst && !trip && !por_pulse) |=> !chip_rst);

    // R7: a qualified low supply never lets reset go.
    a_r7_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && vlow_i && det_en) |=> chip_rst);

    // R9: low supply during the delay goes back to brown-out.
    a_r9_delay_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DELAY && vlow_i && det_en && !por_pulse)
        |=> fsm_state == ST_BROWN);

    // R10: entering brown-out leaves the brown-out flag cleared.
    a_r10_bor_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RUN && trip && !por_pulse) |=> !bor_flag);

    // R10: a software write with no event loads the brown-out flag.
    a_r10_bor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !por_pulse && !trip && fsm_state == ST_BROWN)
        |=> bor_flag == $past(stat_bor_wdata));

    // R11: power-on forces reset and clears both flags.
    a_r11_por_effect: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |=> (chip_rst && !por_flag && !bor_flag));

endmodule

bind bor_supervisor bor_supervisor_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .por_pulse      (por_pulse),
    .vlow_i         (vlow_i),
    .cfg_mode       (cfg_mode),
    .stat_wr        (stat_wr),
    .stat_bor_wdata (stat_bor_wdata),
    .det_en         (det_en),
    .trip           (trip),
    .fsm_state      (fsm_state),
    .chip_rst       (chip_rst),
    .por_flag       (por_flag),
    .bor_flag       (bor_flag)
);

// File: tb/sim_bor_supervisor.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared each cycle against a reference model built from the requirements.
module sim_bor_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int G = 4;
    localparam int P = 16;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_pulse = 1'b0;
    logic vlow_i = 1'b0;
    logic sleep_i = 1'b0;
    logic [1:0] cfg_mode = 2'b11;
    logic pwrt_en = 1'b0;
    logic sw_en_wr = 1'b0;
    logic sw_en_wdata = 1'b0;
    logic stat_wr = 1'b0;
    logic stat_por_wdata = 1'b0;
    logic stat_bor_wdata = 1'b0;
    logic sw_en_rd, por_flag, bor_flag, chip_rst;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference model state: 0 run, 1 brown-out, 2 delay
    int m_st = 0, m_cnt = 0, m_tmr = 0;
    bit m_swen = 0, m_por = 0, m_bor = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bor_supervisor #(.GLITCH_CYC(G), .PWRT_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .por_pulse(por_pulse), .vlow_i(vlow_i),
        .sleep_i(sleep_i), .cfg_mode(cfg_mode), .pwrt_en(pwrt_en),
        .sw_en_wr(sw_en_wr), .sw_en_wdata(sw_en_wdata), .stat_wr(stat_wr),
        .stat_por_wdata(stat_por_wdata), .stat_bor_wdata(stat_bor_wdata),
        .sw_en_rd(sw_en_rd), .por_flag(por_flag), .bor_flag(bor_flag),
        .chip_rst(chip_rst)
    );

    function automatic bit det_now();
        case (cfg_mode)
            2'b00: return 1'b0;
            2'b01: return m_swen;
            2'b10: return !sleep_i;
            default: return 1'b1;
        endcase
    endfunction

    // advance the model by one rising edge using the current inputs
    task automatic model_edge();
        bit det, qual, trip, ev;
        int nst, ncnt, ntmr;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tmr = 0; m_swen = 0; m_por = 0; m_bor = 0;
            return;
        end
        det = det_now();
        qual = vlow_i && det;
        trip = qual && (m_cnt == G - 1);
        ev = 0; nst = m_st; ntmr = m_tmr;
        if (por_pulse) begin
            nst = 2; ntmr = 0;
        end else if (m_st == 0) begin
            if (trip) begin nst = 1; ev = 1; end
        end else if (m_st == 1) begin
            if (!vlow_i) begin nst = pwrt_en ? 2 : 0; ntmr = 0; end
        end else begin
            if (qual) begin nst = 1; ev = 1; ntmr = 0; end
            else if (m_tmr == P - 1) nst = 0;
            else ntmr = m_tmr + 1;
        end
        ncnt = (por_pulse || !qual) ? 0 : ((m_cnt == G - 1) ? m_cnt : m_cnt + 1);
        if (sw_en_wr && cfg_mode == 2'b01) m_swen = sw_en_wdata;
        if (por_pulse) m_por = 0; else if (stat_wr) m_por = stat_por_wdata;
        if (por_pulse || ev) m_bor = 0; else if (stat_wr) m_bor = stat_bor_wdata;
        m_st = nst; m_cnt = ncnt; m_tmr = ntmr;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(chip_rst == (m_st != 0), tag, "chip_rst", chip_rst, m_st != 0);
        check(por_flag == m_por, tag, "por_flag", por_flag, m_por);
        check(bor_flag == m_bor, tag, "bor_flag", bor_flag, m_bor);
        check(sw_en_rd == (m_swen && cfg_mode == 2'b01), tag, "sw_en_rd",
              sw_en_rd, m_swen && cfg_mode == 2'b01);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic steps(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // watchdog: a hung run is reported as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            fails++;
            $display("FAIL R12 watchdog: actual=%0d expected<%0d", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        int hold;
        void'($urandom(32'h5eed_b07));
        // R12: block reset state
        steps(3, "R12");
        check(chip_rst == 0 && por_flag == 0 && bor_flag == 0, "R12",
              "reset state", {chip_rst, por_flag, bor_flag}, 0);
        rst_n = 1'b1;

        // R11: power-on runs the full delay even with pwrt_en low
        pwrt_en = 1'b0; por_pulse = 1'b1;
        step("R11");
        por_pulse = 1'b0;
        hold = 1;
        while (chip_rst && hold < 100) begin step("R11"); if (chip_rst) hold++; end
        check(hold == P, "R11", "reset cycles after por", hold, P);

        // R10: software sets both flags
        stat_wr = 1; stat_por_wdata = 1; stat_bor_wdata = 1;
        step("R10");
        stat_wr = 0;
        check(por_flag && bor_flag, "R10", "flags written", {por_flag, bor_flag}, 3);

        // R6: dip one short of the limit, then exactly the limit (mode 11)
        cfg_mode = 2'b11; pwrt_en = 1'b1;
        vlow_i = 1; steps(G - 1, "R6"); vlow_i = 0; step("R6");
        check(!chip_rst, "R6", "short dip", chip_rst, 0);
        vlow_i = 1; steps(G, "R4");
        check(chip_rst, "R4", "trip at limit in always-on", chip_rst, 1);
        check(!bor_flag && por_flag, "R10", "brown-out signature",
              {por_flag, bor_flag}, 2);
        steps(20, "R7");
        // R8 then R9: recover, dip mid-delay, recover again
        vlow_i = 0; steps(P / 2, "R8");
        vlow_i = 1; step("R9");
        check(chip_rst, "R9", "back to brown-out", chip_rst, 1);
        vlow_i = 0;
        hold = 0;
        while (chip_rst && hold < 100) begin step("R9"); hold++; end
        check(hold == P + 1, "R9", "full delay after rearm", hold, P + 1);

        // R8: no timer, release right after recovery
        pwrt_en = 0; vlow_i = 1; steps(G + 3, "R8"); vlow_i = 0; step("R8");
        check(!chip_rst, "R8", "release without timer", chip_rst, 0);

        // R10: write in the trip cycle loses to the hardware clear
        stat_wr = 1; stat_por_wdata = 1; stat_bor_wdata = 1; step("R10");
        vlow_i = 1; stat_wr = 0; steps(G - 1, "R10");
        stat_wr = 1; step("R10"); stat_wr = 0; vlow_i = 0;
        check(!bor_flag, "R10", "clear beats write", bor_flag, 0);
        step("R10");

        // R3: sleep masks detection in mode 10
        cfg_mode = 2'b10; sleep_i = 1; vlow_i = 1; steps(3 * G, "R3");
        check(!chip_rst, "R3", "no reset in sleep", chip_rst, 0);
        sleep_i = 0; steps(G, "R3");
        check(chip_rst, "R3", "reset after wake", chip_rst, 1);
        vlow_i = 0; steps(2, "R3");

        // R2: software gate in mode 01
        cfg_mode = 2'b01; sw_en_wr = 1; sw_en_wdata = 0; step("R2"); sw_en_wr = 0;
        vlow_i = 1; steps(3 * G, "R2");
        check(!chip_rst, "R2", "gated off", chip_rst, 0);
        sw_en_wr = 1; sw_en_wdata = 1; step("R2"); sw_en_wr = 0;
        check(sw_en_rd, "R2", "readback", sw_en_rd, 1);
        steps(G, "R2");
        check(chip_rst, "R2", "gated on trips", chip_rst, 1);
        vlow_i = 0; steps(2, "R2");

        // R5 and R1: writes ignored and reads 0 outside mode 01
        cfg_mode = 2'b00; sw_en_wr = 1; sw_en_wdata = 0; step("R5"); sw_en_wr = 0;
        check(!sw_en_rd, "R5", "reads zero in mode 00", sw_en_rd, 0);
        vlow_i = 1; steps(3 * G, "R1");
        check(!chip_rst, "R1", "off mode ignores low", chip_rst, 0);
        vlow_i = 0; cfg_mode = 2'b01; step("R5");
        check(sw_en_rd, "R5", "bit kept through ignored write", sw_en_rd, 1);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 7) == 0) vlow_i = ~vlow_i;
            por_pulse = ($urandom_range(0, 99) == 0);
            stat_wr = ($urandom_range(0, 7) == 0);
            stat_por_wdata = 1'($urandom()); stat_bor_wdata = 1'($urandom());
            sw_en_wr = ($urandom_range(0, 7) == 0); sw_en_wdata = 1'($urandom());
            if ($urandom_range(0, 49) == 0) cfg_mode = 2'($urandom());
            if ($urandom_range(0, 19) == 0) sleep_i = ~sleep_i;
            if ($urandom_range(0, 29) == 0) pwrt_en = ~pwrt_en;
            step("R6");
        end
        por_pulse = 0;
        rst_n = 0; step("R12");
        finish_run();
    end

endmodule